// File: doc/BRIEF.md
# Memory-Mapped Terminal I/O Controller

This block is a bus-slave peripheral that gives a processor one character input channel and one character output channel through four word-wide registers. The registers sit at the top of the address space. Each channel has a control word and a data word. In the control word, bit 0 reports whether the channel is ready and bit 1 enables that channel's interrupt. Software can wait on the ready bits by polling, or it can set the enable bits and service the interrupt line.

On the device side, characters from a keyboard-like source arrive on a one-cycle valid strobe with a byte of data. Characters for a display-like sink leave on a valid/ready handshake. After each handshake the transmitter stays busy for a parameterised number of cycles before it accepts another character. A read of the receive data word and a store to the transmit data word both clear their channel's ready flag as a side effect.

Top module: `termio_ctrl`

## Requirements
- R1: After reset the receive control word reads 0 and the transmit control word reads 1 (transmitter idle). `irq` is 0 and `txValid` is 0.
- R2: The register map is: receive control at 0xFFFF0000, receive data at 0xFFFF0004, transmit control at 0xFFFF0008 and transmit data at 0xFFFF000C. Control word bit 0 is Ready and bit 1 is the interrupt enable. All other control bits read 0, and the transmit data word reads 0. A read at any other address returns 0, and a write at any other address has no effect.
- R3: A `rxValid` strobe stores `rxData` and sets receive Ready on the same clock edge. The receive data word then returns that character in bits [7:0], with bits [31:8] equal to 0.
- R4: A read of the receive data word returns the held character and clears receive Ready at the end of that cycle. If a character arrives in the same cycle as the read, the new character is kept and Ready stays 1.
- R5: A character that arrives while receive Ready is 1 overwrites the held character, and Ready stays 1.
- R6: A store to the transmit data word while transmit Ready is 1 drives `txValid` high with the store's low byte on `txData` from the next cycle. In the same cycle transmit Ready drops to 0.
- R7: `txValid` and `txData` hold steady until `txReady` is seen high. Transmit Ready returns to 1 exactly BUSY_CYCLES clock edges after the handshake edge.
- R8: A store to the transmit data word while transmit Ready is 0 is dropped. The pending character and the handshake are unchanged.
- R9: `irq` is high whenever receive Ready and receive enable are both 1, or transmit Ready and transmit enable are both 1. It is a level that follows those flags.
- R10: Writes to a control word change only its enable bit. The Ready bit position is read-only, and writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Byte address of the access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle busRd is high |
| rxValid | input | 1 | Incoming character strobe |
| rxData | input | 8 | Incoming character |
| txValid | output | 1 | Outgoing character pending |
| txData | output | 8 | Outgoing character |
| txReady | input | 1 | Sink accepts the outgoing character |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted ready flag appears at the ports within one cycle, in two places: the next control-word read and the `irq` level once the matching enable is set. A ready bit that clears too early or stays set shows up as a wrong control-word value at the read right after a data access. A busy counter that is off by even one cycle changes which of the consecutive control-word reads after a handshake first returns 1. A wrong held character, or a dropped store that was wrongly accepted, shows up on the next data read or on `txData` while the handshake is pending.

// File: rtl/termio_pkg.sv
package termio_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic       rxLoad;
    logic       rxConsume;
    logic       rxIeWr;
    logic       txIeWr;
    logic       txAccept;
    logic       rdHit;
    logic [1:0] rdIdx;
  } termStrb_t;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_HOLD} txState_t;

  // Word index of each register, taken from address bits [3:2].
  localparam logic [1:0] IDX_RXCTL = 2'd0;
  localparam logic [1:0] IDX_RXDAT = 2'd1;
  localparam logic [1:0] IDX_TXCTL = 2'd2;
  localparam logic [1:0] IDX_TXDAT = 2'd3;
endpackage

// File: rtl/termio_ctl.sv
module termio_ctl
  import termio_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] BASE_ADDR   = 32'hFFFF_0000,
  parameter int          BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              rxValid,
  input  logic              txReady,
  output termStrb_t         strb,
  output logic              txRdy,
  output logic              txValid
);
  localparam int CNT_W = (BUSY_CYCLES > 0) ? $clog2(BUSY_CYCLES + 1) : 1;

  logic       hit;
  logic [1:0] idx;
  txState_t   state;
  logic [CNT_W-1:0] busyCnt;

  // The four registers take one 16-byte window.
  assign hit = (busAddr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign idx = busAddr[3:2];

  assign txRdy   = (state == TX_IDLE);
  assign txValid = (state == TX_SEND);

  always_comb begin
    strb           = '0;
    strb.rxLoad    = rxValid;
    strb.rxConsume = busRd && hit && (idx == IDX_RXDAT);
    strb.rxIeWr    = busWr && hit && (idx == IDX_RXCTL);
    strb.txIeWr    = busWr && hit && (idx == IDX_TXCTL);
    strb.txAccept  = busWr && hit && (idx == IDX_TXDAT) && txRdy;
    strb.rdHit     = busRd && hit;
    strb.rdIdx     = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      busyCnt <= '0;
    end else begin
      case (state)
        TX_IDLE: if (strb.txAccept) state <= TX_SEND;
        TX_SEND: if (txReady) begin
          if (BUSY_CYCLES == 0) state <= TX_IDLE;
          else begin
            state   <= TX_HOLD;
            busyCnt <= CNT_W'(BUSY_CYCLES);
          end
        end
        TX_HOLD: begin
          if (busyCnt <= CNT_W'(1)) state <= TX_IDLE;
          else busyCnt <= busyCnt - 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R6
  tx_accept_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txAccept |=> (txValid && !txRdy));

  // R7
  tx_hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);

  // R8
  tx_busy_store_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && hit && idx == IDX_TXDAT && !txRdy && !txValid) |=> !txValid);
endmodule

// File: rtl/termio_dp.sv
module termio_dp
  import termio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  termStrb_t         strb,
  input  logic              txRdy,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CHAR_W-1:0] rxData,
  output logic [DATA_W-1:0] busRdata,
  output logic [CHAR_W-1:0] txData,
  output logic              irq
);
  logic              rxRdy, rxIe, txIe;
  logic [CHAR_W-1:0] rxChar, txChar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxRdy  <= 1'b0;
      rxIe   <= 1'b0;
      txIe   <= 1'b0;
      rxChar <= '0;
      txChar <= '0;
    end else begin
      // An arrival wins over a read in the same cycle.
      if (strb.rxLoad) begin
        rxRdy  <= 1'b1;
        rxChar <= rxData;
      end else if (strb.rxConsume) begin
        rxRdy  <= 1'b0;
      end
      if (strb.rxIeWr)   rxIe   <= busWdata[1];
      if (strb.txIeWr)   txIe   <= busWdata[1];
      if (strb.txAccept) txChar <= busWdata[CHAR_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdHit) begin
      case (strb.rdIdx)
        IDX_RXCTL: busRdata[1:0] = {rxIe, rxRdy};
        IDX_RXDAT: busRdata[CHAR_W-1:0] = rxChar;
        IDX_TXCTL: busRdata[1:0] = {txIe, txRdy};
        default:   busRdata = '0;
      endcase
    end
  end

  assign txData = txChar;
  assign irq    = (rxRdy && rxIe) || (txRdy && txIe);

  // R3
  rx_arrival_sets_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxLoad |=> (rxRdy && rxChar == $past(rxData)));

  // R4
  rx_read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxConsume && !strb.rxLoad) |=> !rxRdy);

  // R10
  ready_not_writable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxIeWr && !strb.rxLoad && !strb.rxConsume) |=> $stable(rxRdy));

  // R6
  tx_char_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txRdy && !strb.txAccept) |=> $stable(txChar));
endmodule

// File: rtl/termio_ctrl.sv
module termio_ctrl
  import termio_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          CHAR_W      = 8,
  parameter logic [31:0] BASE_ADDR   = 32'hFFFF_0000,
  parameter int          BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txReady,
  output logic              irq
);
  termStrb_t strb;
  logic      txRdy;
  logic      unusedAddrBits;

  assign unusedAddrBits = ^busAddr[1:0];

  termio_ctl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .BUSY_CYCLES(BUSY_CYCLES)
  ) ctlInst (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .rxValid(rxValid), .txReady(txReady), .strb(strb), .txRdy(txRdy),
    .txValid(txValid)
  );

  termio_dp #(
    .DATA_W(DATA_W), .CHAR_W(CHAR_W)
  ) dpInst (
    .clk(clk), .rstN(rstN), .strb(strb), .txRdy(txRdy), .busWdata(busWdata),
    .rxData(rxData), .busRdata(busRdata), .txData(txData), .irq(irq)
  );
endmodule

// File: tb/tb_termio_ctrl.sv
module tb_termio_ctrl;
  localparam logic [31:0] RXC = 32'hFFFF_0000;
  localparam logic [31:0] RXD = 32'hFFFF_0004;
  localparam logic [31:0] TXC = 32'hFFFF_0008;
  localparam logic [31:0] TXD = 32'hFFFF_000C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  termio_ctrl dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txData(txData), .txReady(txReady), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares every read against the queued expectation.
  always @(negedge clk) begin
    if (busRd && expQ.size() > 0) chk(busRdata, expQ.pop_front(), tagQ.pop_front());
  end

  task automatic cyc;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; busRd = 1'b1; expQ.push_back(exp); tagQ.push_back(tag);
    cyc; busRd = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    cyc; busWr = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] c);
    rxValid = 1'b1; rxData = c;
    cyc; rxValid = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) cyc;
    rstN = 1'b1; cyc;
    // R1 reset state
    chk(irq, 0, "R1 irq");
    chk(txValid, 0, "R1 txValid");
    rd(RXC, 32'h0, "R1 rx ctrl");
    rd(TXC, 32'h1, "R1 tx ctrl");

    // R3 arrival, R4 read clears
    rxPush(8'h41);
    rd(RXC, 32'h1, "R3 ready");
    rd(RXD, 32'h41, "R3 data");
    rd(RXC, 32'h0, "R4 cleared");

    // R5 overwrite
    rxPush(8'h11);
    rxPush(8'h22);
    rd(RXC, 32'h1, "R5 ready kept");
    rd(RXD, 32'h22, "R5 newest char");

    // R4 arrival coincides with read
    rxPush(8'h55);
    rxValid = 1'b1; rxData = 8'h66;
    rd(RXD, 32'h55, "R4 old char on read");
    rxValid = 1'b0;
    rd(RXC, 32'h1, "R4 arrival wins");
    rd(RXD, 32'h66, "R4 new char");

    // R10 ready bit read-only, R2 other bits zero
    wr(RXC, 32'hFFFF_FFFD);
    rd(RXC, 32'h0, "R10 ready ignored");
    wr(RXC, 32'h2);
    rd(RXC, 32'h2, "R2 enable bit");
    chk(irq, 0, "R9 no ready no irq");
    rxPush(8'h77);
    chk(irq, 1, "R9 rx irq");
    rd(RXC, 32'h3, "R2 both bits");
    rd(RXD, 32'h77, "R3 data");
    chk(irq, 0, "R9 irq drops");
    wr(RXC, 32'h0);

    // R2 outside the window
    rd(32'hFFFF_0010, 32'h0, "R2 outside read");
    rd(32'h0000_0004, 32'h0, "R2 low read");
    wr(32'h0000_000C, 32'h99);
    chk(txValid, 0, "R2 outside write");
    rd(TXD, 32'h0, "R2 tx data reads zero");

    // R6 transmit, R8 drop, R7 hold and busy time
    wr(TXD, 32'hABCD_EF5A);
    chk(txValid, 1, "R6 txValid");
    chk(txData, 8'h5A, "R6 txData");
    rd(TXC, 32'h0, "R6 ready low");
    wr(TXD, 32'h13);
    repeat (3) cyc;
    chk(txValid, 1, "R7 held");
    chk(txData, 8'h5A, "R8 store dropped");
    txReady = 1'b1; cyc; txReady = 1'b0;
    chk(txValid, 0, "R7 handshake done");
    for (int i = 0; i < 4; i++) rd(TXC, 32'h0, "R7 busy");
    rd(TXC, 32'h1, "R7 ready after busy");

    // R9 transmit interrupt
    wr(TXC, 32'h2);
    chk(irq, 1, "R9 tx irq");
    txReady = 1'b1;
    wr(TXD, 32'h44);
    chk(irq, 0, "R9 tx irq drops");
    chk(txData, 8'h44, "R6 second char");
    repeat (6) cyc;
    chk(irq, 1, "R9 tx irq returns");
    txReady = 1'b0;

    done = 1'b1;
    summary();
  end
endmodule